// File: doc/BRIEF.md
# Serial Register Front End with Time Snapshot and Indirect Memory Window

This block is the serial slave side of a timekeeping register map. A host selects it by pulling chip select low, sends one header byte and then streams data bytes in or out. The header gives the direction and the starting register index. After each completed data byte, an internal index pointer moves on, wraps at the end of the time range and skips nothing. Reserved indices get no answer. The block drives a register read/write port toward an external register file. It also pulses a snapshot strobe that tells the time logic to copy the running counters into the readable buffer.

Two indices form a window onto a 256-byte memory. Index 18h holds a memory pointer that lives inside this block. Index 19h reads or writes the memory byte at that pointer. While the window is used, the register index stays parked on 19h and the memory pointer advances after each byte.

The controller is a four-state machine clocked by the system clock. The serial pins are oversampled through synchronisers. The states are:
- IDLE: waits for chip select to fall.
- ADDR: shifts in the header byte.
- LOAD: fetches the next outgoing byte.
- DATA: shifts one data byte in both directions.

The transitions are:
- IDLE to ADDR on the chip-select fall.
- ADDR to LOAD after the eighth header bit.
- LOAD to DATA on the following cycle.
- DATA to LOAD after every eighth data bit.
- Any state to IDLE whenever chip select is high.

Top module: `rtc_spi_regif`

## Requirements
- R1: The first byte after chip select falls is the header, received most significant bit first. Its bit 7 set to 1 marks a write and set to 0 marks a read. Bits 6:0 give the starting index.
- R2: The clock idle level is taken from the serial clock's level when chip select falls, so both polarities work. Input data is sampled on the trailing edge and output data changes on the leading edge (clock phase 1).
- R3: Each completed data byte in the time range advances the index by one. Index 13h wraps to 00h, so a write header of 93h continues at 80h.
- R4: Indices 14h to 17h and 1Ah to 7Fh are reserved. A reserved index never drives the data output and never produces a write strobe, and the index does not advance.
- R5: The snapshot strobe pulses for one clock when chip select falls and again when a completed byte at index 13h wraps the index to 00h.
- R6: The output enable stays low during the header, during every write transfer and during reads of reserved indices. It rises only once the first read byte is loaded.
- R7: Index 18h reads and writes the 8-bit memory pointer. Index 19h reads or writes the memory at that pointer, keeps the index at 19h, and increments the pointer after each byte, rolling FFh to 00h.
- R8: A write takes effect only after all eight bits of its data byte have arrived. A byte cut short by chip select rising is dropped.
- R9: Chip select rising abandons the transfer, and the next selection starts again with a header byte.
- R10: A completed write byte to indices 00h to 13h shows the index and the byte on the register port, with a write strobe one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_oe | output | 1 | Output enable for dout (low means high impedance) |
| reg_addr | output | 7 | Register index for reads and writes |
| reg_wdata | output | 8 | Register write byte |
| reg_we | output | 1 | Register write strobe |
| reg_rdata | input | 8 | Register read byte at reg_addr (combinational) |
| snap | output | 1 | Snapshot request strobe |
| mem_addr | output | 8 | Memory address (the memory pointer) |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read byte at mem_addr (combinational) |

## Verification
The assertions rely on three things about the inputs:
- Each serial clock half period lasts several system clocks, so a LOAD cycle always fits between a header's last trailing edge and the next leading edge.
- The serial clock sits at its idle level whenever chip select changes.
- The register and memory read data answer combinationally to the address outputs.

The bench host holds the half period at eight system clocks and moves the clock to its idle level before every chip-select edge. It keeps chip select high for several half periods between transfers. Its register file and memory models answer in the same cycle.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LOAD,
        ST_DATA
    } spi_state_e;

    typedef enum logic [1:0] {
        RG_TIME,
        RG_MPTR,
        RG_MDATA,
        RG_RSVD
    } region_e;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_s,
    output logic sclk_s,
    output logic din_s,
    output logic cs_fall,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] cs_q, sck_q, di_q;
    logic         cs_p, sck_p;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cs_q[g]  <= 1'b1;
                    sck_q[g] <= 1'b0;
                    di_q[g]  <= 1'b0;
                end else if (g == 0) begin
                    cs_q[g]  <= cs_n;
                    sck_q[g] <= sclk;
                    di_q[g]  <= din;
                end else begin
                    cs_q[g]  <= cs_q[(g == 0) ? 0 : g - 1];
                    sck_q[g] <= sck_q[(g == 0) ? 0 : g - 1];
                    di_q[g]  <= di_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_p  <= 1'b1;
            sck_p <= 1'b0;
        end else begin
            cs_p  <= cs_q[TOP];
            sck_p <= sck_q[TOP];
        end
    end

    assign cs_s      = cs_q[TOP];
    assign sclk_s    = sck_q[TOP];
    assign din_s     = di_q[TOP];
    assign cs_fall   = cs_p & ~cs_q[TOP];
    assign sclk_rise = ~sck_p & sck_q[TOP];
    assign sclk_fall = sck_p & ~sck_q[TOP];
endmodule

// File: rtl/rtc_spi_addr_map.sv
module rtc_spi_addr_map
    import rtc_spi_pkg::*;
#(
    parameter int              IDX_W     = 7,
    parameter logic [IDX_W-1:0] LAST_IDX  = 7'h13,
    parameter logic [IDX_W-1:0] RSVD_LO   = 7'h14,
    parameter logic [IDX_W-1:0] MPTR_IDX  = 7'h18,
    parameter logic [IDX_W-1:0] MDATA_IDX = 7'h19
) (
    input  logic [IDX_W-1:0] idx,
    output region_e          region,
    output logic [IDX_W-1:0] next_idx,
    output logic             wrap
);
    always_comb begin
        if (idx <= LAST_IDX)            region = RG_TIME;
        else if (idx == MPTR_IDX)       region = RG_MPTR;
        else if (idx == MDATA_IDX)      region = RG_MDATA;
        else                            region = RG_RSVD;

        wrap = (idx == LAST_IDX);
        unique case (region)
            RG_TIME:  next_idx = wrap ? '0 : idx + 1'b1;
            RG_MPTR:  next_idx = idx + 1'b1;
            default:  next_idx = idx;
        endcase
    end

    logic unused_lo;
    assign unused_lo = ^RSVD_LO;
endmodule

// File: rtl/rtc_spi_regif.sv
module rtc_spi_regif
    import rtc_spi_pkg::*;
#(
    parameter int               DW          = 8,
    parameter int               IDX_W       = DW - 1,
    parameter int               MAW         = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [IDX_W-1:0] LAST_IDX    = 7'h13,
    parameter logic [IDX_W-1:0] RSVD_LO     = 7'h14,
    parameter logic [IDX_W-1:0] MPTR_IDX    = 7'h18,
    parameter logic [IDX_W-1:0] MDATA_IDX   = 7'h19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    output logic             dout,
    output logic             dout_oe,
    output logic [IDX_W-1:0] reg_addr,
    output logic [DW-1:0]    reg_wdata,
    output logic             reg_we,
    input  logic [DW-1:0]    reg_rdata,
    output logic             snap,
    output logic [MAW-1:0]   mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we,
    input  logic [DW-1:0]    mem_rdata
);
    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

    spi_state_e       st, st_nx;
    logic             cs_s, sclk_s, din_s, cs_fall, sclk_rise, sclk_fall;
    logic             cpol, wr_dir, oe_q, dout_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    rx_sr, tx_sr, rx_nx, load_val;
    logic [IDX_W-1:0] ptr, ptr_nx;
    logic [MAW-1:0]   mem_ptr;
    region_e          region;
    logic             wrap, lead, trail, last_bit, byte_done;

    rtc_spi_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cs_s(cs_s), .sclk_s(sclk_s), .din_s(din_s), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    rtc_spi_addr_map #(
        .IDX_W(IDX_W), .LAST_IDX(LAST_IDX), .RSVD_LO(RSVD_LO),
        .MPTR_IDX(MPTR_IDX), .MDATA_IDX(MDATA_IDX)
    ) i_map (
        .idx(ptr), .region(region), .next_idx(ptr_nx), .wrap(wrap)
    );

    assign lead      = cpol ? sclk_fall : sclk_rise;
    assign trail     = cpol ? sclk_rise : sclk_fall;
    assign last_bit  = (bit_cnt == CNT_LAST);
    assign rx_nx     = {rx_sr[DW-2:0], din_s};
    assign byte_done = (st == ST_DATA) && !cs_s && trail && last_bit;

    always_comb begin
        unique case (region)
            RG_TIME:  load_val = reg_rdata;
            RG_MPTR:  load_val = DW'(mem_ptr);
            RG_MDATA: load_val = mem_rdata;
            default:  load_val = '0;
        endcase
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (cs_fall) st_nx = ST_ADDR;
            ST_ADDR: if (cs_s) st_nx = ST_IDLE;
                     else if (trail && last_bit) st_nx = ST_LOAD;
            ST_LOAD: st_nx = cs_s ? ST_IDLE : ST_DATA;
            ST_DATA: if (cs_s) st_nx = ST_IDLE;
                     else if (trail && last_bit) st_nx = ST_LOAD;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // shifters, pointers and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol    <= 1'b0;
            wr_dir  <= 1'b0;
            oe_q    <= 1'b0;
            dout_q  <= 1'b0;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            ptr     <= '0;
            mem_ptr <= '0;
        end else if (cs_s) begin
            oe_q    <= 1'b0;
            bit_cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (cs_fall) cpol <= sclk_s;
                    bit_cnt <= '0;
                end
                ST_ADDR: begin
                    if (trail) begin
                        rx_sr   <= rx_nx;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            wr_dir <= rx_nx[DW-1];
                            ptr    <= rx_nx[IDX_W-1:0];
                        end
                    end
                end
                ST_LOAD: begin
                    tx_sr   <= load_val;
                    oe_q    <= !wr_dir && (region != RG_RSVD);
                    bit_cnt <= '0;
                end
                ST_DATA: begin
                    if (lead) begin
                        dout_q <= tx_sr[DW-1];
                        tx_sr  <= {tx_sr[DW-2:0], 1'b0};
                    end
                    if (trail) begin
                        rx_sr   <= rx_nx;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            ptr <= ptr_nx;
                            if (wr_dir && region == RG_MPTR) mem_ptr <= MAW'(rx_nx);
                            if (region == RG_MDATA)          mem_ptr <= mem_ptr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        dout      = dout_q;
        dout_oe   = oe_q;
        reg_addr  = ptr;
        reg_wdata = rx_nx;
        reg_we    = byte_done && wr_dir && (region == RG_TIME);
        mem_addr  = mem_ptr;
        mem_wdata = rx_nx;
        mem_we    = byte_done && wr_dir && (region == RG_MDATA);
        snap      = ((st == ST_IDLE) && cs_fall) || (byte_done && wrap);
    end
endmodule

// File: rtl/rtc_spi_regif_chk.sv
module rtc_spi_regif_chk
    import rtc_spi_pkg::*;
#(
    parameter int               IDX_W    = 7,
    parameter int               MAW      = 8,
    parameter logic [IDX_W-1:0] LAST_IDX = 7'h13
) (
    input logic             clk,
    input logic             rst_n,
    input spi_state_e       st,
    input logic             reg_we,
    input logic [IDX_W-1:0] reg_addr,
    input logic             mem_we,
    input logic [MAW-1:0]   mem_addr,
    input logic             dout_oe,
    input logic             snap
);
    AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_addr <= LAST_IDX); // R10

    AST_WE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || mem_we) |-> st == ST_DATA); // R8

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we, mem_we})); // R7

    AST_MPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> mem_addr == MAW'($past(mem_addr) + 1'b1)); // R7

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_addr == (($past(reg_addr) == LAST_IDX) ? '0
                                 : IDX_W'($past(reg_addr) + 1'b1))); // R3

    AST_OE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> st == ST_DATA); // R6

    AST_SNAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> !snap); // R5
endmodule

bind rtc_spi_regif rtc_spi_regif_chk #(
    .IDX_W(IDX_W), .MAW(MAW), .LAST_IDX(LAST_IDX)
) i_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .reg_we(reg_we), .reg_addr(reg_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .dout_oe(dout_oe), .snap(snap)
);

// File: tb/test_rtc_spi_regif.sv
module test_rtc_spi_regif;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic       dout, dout_oe, reg_we, snap, mem_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, mem_wdata, mem_rdata, mem_addr;

    logic [7:0] regs_m [0:19];
    logic [7:0] exp_regs [0:19];
    logic [7:0] mem_m [0:255];
    logic [7:0] exp_mem [0:255];
    logic [7:0] exp_mptr;
    logic [7:0] tx_buf [0:15];
    logic [7:0] rx_buf [0:15];
    logic       oe_byte [0:15];
    logic       addr_oe;
    int         errors = 0, checks = 0;
    int         snap_cnt = 0, snap_exp = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    rtc_spi_regif i_rtc_spi_regif (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .snap(snap), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    assign reg_rdata = (reg_addr < 7'd20) ? regs_m[reg_addr[4:0]] : 8'h00;
    assign mem_rdata = mem_m[mem_addr];

    always @(posedge clk) begin
        if (reg_we && reg_addr < 7'd20) regs_m[reg_addr[4:0]] <= reg_wdata;
        if (mem_we) mem_m[mem_addr] <= mem_wdata;
        if (rst_n && snap) snap_cnt <= snap_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit rsvd(input int p);
        return (p >= 'h14 && p <= 'h17) || p > 'h19;
    endfunction

    function automatic int adv(input int p);
        if (rsvd(p) || p == 'h19) return p;
        if (p == 'h13) return 0;
        return p + 1;
    endfunction

    // one selection: header, n data bytes, last byte cut to 'cut' bits
    task automatic xfer(input bit cpol, input logic [7:0] hdr, input int n, input int cut);
        logic [7:0] b;
        @(negedge clk); sclk = cpol;
        repeat (H) @(negedge clk);
        cs_n = 1'b0;
        addr_oe = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = -1; i < n; i++) begin
            int nb = (i == n - 1) ? cut : 8;
            b = (i < 0) ? hdr : tx_buf[i];
            if (i >= 0) oe_byte[i] = 1'b1;
            for (int k = 0; k < nb; k++) begin
                sclk = ~cpol; din = b[7-k];
                repeat (H) @(negedge clk);
                if (i < 0) addr_oe = addr_oe | dout_oe;
                else begin
                    rx_buf[i] = {rx_buf[i][6:0], dout};
                    oe_byte[i] = oe_byte[i] & dout_oe;
                end
                sclk = cpol;
                repeat (H) @(negedge clk);
            end
        end
        cs_n = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    task automatic run(input bit cpol, input bit wr, input int idx, input int n, input int cut);
        int p = idx;
        xfer(cpol, {wr, idx[6:0]}, n, cut);
        snap_exp++;
        chk(addr_oe == 1'b0, "R6 oe low in header", addr_oe, 0);
        for (int i = 0; i < n; i++) begin
            if (i == n - 1 && cut != 8) break;
            if (!wr) begin
                chk(oe_byte[i] == !rsvd(p), "R4/R6 read enable", oe_byte[i], !rsvd(p));
                if (p <= 'h13)      chk(rx_buf[i] == exp_regs[p], "R1/R2/R3 read data", rx_buf[i], exp_regs[p]);
                else if (p == 'h18) chk(rx_buf[i] == exp_mptr, "R7 pointer read", rx_buf[i], exp_mptr);
                else if (p == 'h19) begin
                    chk(rx_buf[i] == exp_mem[exp_mptr], "R7 window read", rx_buf[i], exp_mem[exp_mptr]);
                    exp_mptr++;
                end
            end else begin
                chk(oe_byte[i] == 1'b0, "R6 oe low in write", oe_byte[i], 0);
                if (p <= 'h13)      exp_regs[p] = tx_buf[i];
                else if (p == 'h18) exp_mptr = tx_buf[i];
                else if (p == 'h19) begin
                    exp_mem[exp_mptr] = tx_buf[i];
                    exp_mptr++;
                end
            end
            if (p == 'h13) snap_exp++;
            p = adv(p);
        end
        chk(snap_cnt == snap_exp, "R5 snapshot count", snap_cnt, snap_exp);
    endtask

    task automatic cmp_all(input string req);
        int bad = 0;
        for (int i = 0; i < 20; i++) if (regs_m[i] !== exp_regs[i]) bad++;
        for (int i = 0; i < 256; i++) if (mem_m[i] !== exp_mem[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 20; i++) begin regs_m[i] = 8'($urandom); exp_regs[i] = regs_m[i]; end
        for (int i = 0; i < 256; i++) begin mem_m[i] = 8'($urandom); exp_mem[i] = mem_m[i]; end
        exp_mptr = 8'h00;
        repeat (5) @(negedge clk);
        chk(!dout_oe && !reg_we && !mem_we && !snap, "reset outputs idle", dout_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 R2: single reads in both clock polarities
        run(1'b0, 1'b0, 'h05, 1, 8);
        run(1'b1, 1'b0, 'h05, 1, 8);
        // R3 R5: read wrap 13h -> 00h with extra snapshot
        run(1'b1, 1'b0, 'h12, 4, 8);
        // R10 R3: write wrap 93h -> 80h
        tx_buf[0] = 8'hA5; tx_buf[1] = 8'h3C; tx_buf[2] = 8'h0F;
        run(1'b0, 1'b1, 'h13, 3, 8);
        cmp_all("R10/R3 write wrap");
        run(1'b0, 1'b0, 'h13, 3, 8);
        // R4: reserved reads and writes
        run(1'b0, 1'b0, 'h15, 2, 8);
        tx_buf[0] = 8'hFF; tx_buf[1] = 8'hEE;
        run(1'b1, 1'b1, 'h16, 2, 8);
        run(1'b1, 1'b1, 'h7F, 2, 8);
        cmp_all("R4 reserved write ignored");
        // R7: memory window with pointer roll-over
        tx_buf[0] = 8'hFE;
        run(1'b0, 1'b1, 'h18, 1, 8);
        run(1'b1, 1'b0, 'h18, 1, 8);
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
        run(1'b0, 1'b1, 'h19, 3, 8);
        cmp_all("R7 window write");
        run(1'b1, 1'b0, 'h18, 2, 8);
        tx_buf[0] = 8'hFD;
        run(1'b0, 1'b1, 'h18, 1, 8);
        run(1'b0, 1'b0, 'h19, 4, 8);
        // R8 R9: partial byte dropped, next selection restarts
        tx_buf[0] = 8'h99; tx_buf[1] = 8'h66;
        run(1'b0, 1'b1, 'h02, 2, 5);
        cmp_all("R8 partial byte dropped");
        run(1'b1, 1'b1, 'h04, 1, 3);
        cmp_all("R8 partial first byte dropped");
        run(1'b0, 1'b0, 'h02, 3, 8);
        chk(dout_oe == 1'b0, "R9 idle after abort", dout_oe, 0);

        // constrained random mix
        for (int t = 0; t < 40; t++) begin
            int sel = $urandom_range(0, 9);
            int idx = (sel == 9) ? 'h19 : (sel == 8) ? 'h18 : $urandom_range(0, 'h13);
            int n = $urandom_range(1, 5);
            for (int i = 0; i < n; i++) tx_buf[i] = 8'($urandom);
            run(1'($urandom), 1'($urandom), idx, n, 8);
        end
        cmp_all("R1/R3/R7 random final state");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule